// File: doc/BRIEF.md
# Charlieplexed Nineteen-LED Scan Driver

This block lights nineteen LEDs that share five tri-state pads. Two pads meet at each LED, so a pad is never wired to a single row or column. The block makes one sweep through five phases. In each phase a single pad drives high as the common strobe. Every pad whose LED is enabled in the frame sinks current by driving low. All other pads float. Between two phases every pad is released for one clock, so a pad that has just been a strobe is never driven low in the same cycle, and a pad that has just been a sink is never driven high in the same cycle.

A pulse on `start` while the block is idle captures a 24-bit frame and a sweep count. The block then repeats the five-phase sweep that many times, holding each phase for a parameterised number of clocks. A one-cycle `done` pulse ends the run. The pads themselves lie outside this block: each pad appears as one output-enable bit and one output-data bit. Bit 16 of the frame lights no LED. It flags the last frame of a pattern and is passed to the pattern source on `last_frame`.

Top module: `charlie_scan`

## Requirements
- R1: After reset `pin_oe`, `pin_out`, `busy`, `done` and `last_frame` are all 0.
- R2: `start` is accepted only while `busy` is 0. On acceptance `frame_in` and `sweeps_in` are captured and `busy` is 1 from the next cycle. While busy, changes on `frame_in`, `sweeps_in` and `start` have no effect on the pads or on the length of the run.
- R3: The strobe pad steps through pads 0, 1, 2, 3, 4 in that order within every sweep. The strobe pad has `pin_oe`=1 and `pin_out`=1.
- R4: In each phase a sink pad has `pin_oe`=1 and `pin_out`=0 exactly when its frame bit is 1. Each entry below is written as pad←frame bit. Phase 0: pad1←11, pad2←15, pad3←13. Phase 1: pad0←12, pad2←8, pad3←22, pad4←2. Phase 2: pad0←0, pad1←23, pad3←9, pad4←6. Phase 3: pad0←14, pad1←21, pad2←10, pad4←4. Phase 4: pad0←7, pad1←1, pad2←5, pad3←3.
- R5: A pad is undriven (`pin_oe`=0, `pin_out`=0) when it is neither the strobe nor an enabled sink. `pin_out` is never 1 on a pad whose `pin_oe` is 0.
- R6: Each phase begins with exactly one cycle in which all pads are released. The drive pattern is then held for DWELL cycles, so one sweep takes 5·(DWELL+1) cycles.
- R7: A run consists of `sweeps_in` sweeps. A value of 0 means 2^CNT_W sweeps.
- R8: `done` is 1 for exactly one cycle, the cycle right after the last drive cycle. In that same cycle `busy` is 0 and every pad is released.
- R9: `last_frame` equals bit 16 of the most recently accepted frame.
- R10: Frame bits 16 to 20 never enable any pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (used only when idle) |
| frame_in | input | 24 | LED frame word |
| sweeps_in | input | CNT_W | Number of sweeps, 0 = 2^CNT_W |
| pin_oe | output | 5 | Pad output enables |
| pin_out | output | 5 | Pad output data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| last_frame | output | 1 | End-of-pattern flag of the captured frame |

## Verification
A wrong phase register shows at the pads within one cycle as a misplaced strobe or as sinks taken from another phase's bits. A dwell counter that is off by one first shows at the next phase boundary: the release cycle moves, and the bench checks that release cycle on every phase. An error in the sweep counter shows only at the end of the run, where `done` comes a whole sweep early or late. The 256-sweep run with a count of 0 catches wrap errors in that counter.

// File: rtl/charlie_scan_pkg.sv
package charlie_scan_pkg;

  localparam int NPADS   = 5;
  localparam int NPHASES = 5;
  localparam int FRAME_W = 24;
  localparam int PH_W    = 3;
  localparam int END_BIT = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_DRIVE = 2'd2
  } scan_st_e;

  // Returns {used, frame bit index} for a sink pad in a given phase.
  function automatic logic [5:0] sink_bit(input logic [PH_W-1:0] ph, input int pad);
    logic [5:0] r;
    r = 6'd0;
    case (ph)
      3'd0: case (pad) 1: r = {1'b1, 5'd11}; 2: r = {1'b1, 5'd15}; 3: r = {1'b1, 5'd13}; default: r = 6'd0; endcase
      3'd1: case (pad) 0: r = {1'b1, 5'd12}; 2: r = {1'b1, 5'd8};  3: r = {1'b1, 5'd22}; 4: r = {1'b1, 5'd2}; default: r = 6'd0; endcase
      3'd2: case (pad) 0: r = {1'b1, 5'd0};  1: r = {1'b1, 5'd23}; 3: r = {1'b1, 5'd9};  4: r = {1'b1, 5'd6}; default: r = 6'd0; endcase
      3'd3: case (pad) 0: r = {1'b1, 5'd14}; 1: r = {1'b1, 5'd21}; 2: r = {1'b1, 5'd10}; 4: r = {1'b1, 5'd4}; default: r = 6'd0; endcase
      3'd4: case (pad) 0: r = {1'b1, 5'd7};  1: r = {1'b1, 5'd1};  2: r = {1'b1, 5'd5};  3: r = {1'b1, 5'd3}; default: r = 6'd0; endcase
      default: r = 6'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/charlie_phase_map.sv
module charlie_phase_map
  import charlie_scan_pkg::*;
(
  input  logic [PH_W-1:0]    phase,
  input  logic [FRAME_W-1:0] frame,
  output logic [NPADS-1:0]   strobe,
  output logic [NPADS-1:0]   sink
);

  for (genvar g = 0; g < NPADS; g++) begin : g_pad
    logic [5:0] sel;
    assign sel       = sink_bit(phase, g);
    assign strobe[g] = (phase == PH_W'(g));
    assign sink[g]   = sel[5] & frame[sel[4:0]];
  end

endmodule

// File: rtl/charlie_scan_seq.sv
module charlie_scan_seq
  import charlie_scan_pkg::*;
#(
  parameter int DWELL = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] sweeps_in,
  output logic             accept,
  output logic             drive_n,
  output logic [PH_W-1:0]  phase_n,
  output logic             busy,
  output logic             done
);

  localparam int DW_W = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

  scan_st_e         st, st_n;
  logic [PH_W-1:0]  ph;
  logic [DW_W-1:0]  dw, dw_n;
  logic [CNT_W-1:0] sw, sw_n;
  logic             done_n;

  always_comb begin
    st_n    = st;
    phase_n = ph;
    dw_n    = dw;
    sw_n    = sw;
    done_n  = 1'b0;
    accept  = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        accept  = 1'b1;
        st_n    = ST_GAP;
        phase_n = '0;
        sw_n    = sweeps_in;
      end
      ST_GAP: begin
        st_n = ST_DRIVE;
        dw_n = '0;
      end
      ST_DRIVE: begin
        if (dw == DW_LAST) begin
          if (ph == PH_W'(NPHASES - 1)) begin
            phase_n = '0;
            if (sw == CNT_W'(1)) begin
              st_n   = ST_IDLE;
              done_n = 1'b1;
            end else begin
              sw_n = sw - CNT_W'(1);
              st_n = ST_GAP;
            end
          end else begin
            phase_n = ph + PH_W'(1);
            st_n    = ST_GAP;
          end
        end else begin
          dw_n = dw + DW_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign drive_n = (st_n == ST_DRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      ph   <= '0;
      dw   <= '0;
      sw   <= '0;
      done <= 1'b0;
      busy <= 1'b0;
    end else begin
      st   <= st_n;
      ph   <= phase_n;
      dw   <= dw_n;
      sw   <= sw_n;
      done <= done_n;
      busy <= (st_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/charlie_scan.sv
module charlie_scan
  import charlie_scan_pkg::*;
#(
  parameter int DWELL = 4,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [23:0]        frame_in,
  input  logic [CNT_W-1:0]   sweeps_in,
  output logic [4:0]         pin_oe,
  output logic [4:0]         pin_out,
  output logic               busy,
  output logic               done,
  output logic               last_frame
);

  logic [FRAME_W-1:0] frame_q;
  logic               accept, drive_n;
  logic [PH_W-1:0]    phase_n;
  logic [NPADS-1:0]   strobe, sink;

  charlie_scan_seq #(.DWELL(DWELL), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sweeps_in (sweeps_in),
    .accept    (accept),
    .drive_n   (drive_n),
    .phase_n   (phase_n),
    .busy      (busy),
    .done      (done)
  );

  charlie_phase_map u_map (
    .phase  (phase_n),
    .frame  (frame_q),
    .strobe (strobe),
    .sink   (sink)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= '0;
      last_frame <= 1'b0;
      pin_oe     <= '0;
      pin_out    <= '0;
    end else begin
      if (accept) begin
        frame_q    <= frame_in;
        last_frame <= frame_in[END_BIT];
      end
      pin_oe  <= drive_n ? (strobe | sink) : '0;
      pin_out <= drive_n ? strobe : '0;
    end
  end

endmodule

// File: rtl/charlie_scan_chk.sv
module charlie_scan_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [4:0] pin_oe,
  input logic [4:0] pin_out,
  input logic       busy,
  input logic       done
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_out)); // R3

  AST_HIGH_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == 5'd0); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pin_oe == 5'd0)); // R8

  AST_GAP_BEFORE_PHASE: assert property (@(posedge clk) disable iff (rst)
    (pin_out != 5'd0 && pin_out != $past(pin_out)) |-> ($past(pin_oe) == 5'd0)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

endmodule

bind charlie_scan charlie_scan_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .pin_oe  (pin_oe),
  .pin_out (pin_out),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_charlie_scan.sv
`timescale 1ns/1ps
module sim_charlie_scan;

  localparam int D  = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [23:0]   frame_in = '0;
  logic [CW-1:0] sweeps_in = '0;
  logic [4:0]    pin_oe, pin_out;
  logic          busy, done, last_frame;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  charlie_scan #(.DWELL(D), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .frame_in(frame_in),
    .sweeps_in(sweeps_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .busy(busy), .done(done), .last_frame(last_frame)
  );

  // Sink map from R4, bit order {pad4..pad0}
  function automatic logic [4:0] exp_sink(int ph, logic [23:0] f);
    case (ph)
      0: return {1'b0, f[13], f[15], f[11], 1'b0};
      1: return {f[2], f[22], f[8], 1'b0, f[12]};
      2: return {f[6], f[9], 1'b0, f[23], f[0]};
      3: return {f[4], 1'b0, f[10], f[21], f[14]};
      default: return {1'b0, f[3], f[5], f[1], f[7]};
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [23:0] f, input int cnt, input bit noisy);
    int n;
    logic [4:0] ex_oe, ex_out;
    @(negedge clk);
    frame_in  = f;
    sweeps_in = CW'(cnt);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = ((cnt == 0) ? (1 << CW) : cnt) * 5 * (D + 1);
    for (int k = 1; k <= n; k++) begin
      int t, ph, pos;
      t   = k - 1;
      ph  = (t / (D + 1)) % 5;
      pos = t % (D + 1);
      if (pos == 0) begin
        ex_oe = '0; ex_out = '0;
      end else begin
        ex_out = 5'(1 << ph);
        ex_oe  = ex_out | exp_sink(ph, f);
      end
      chk(busy == 1'b1 && done == 1'b0, "R2 busy during run", {busy, done}, 2'b10);
      chk(pin_out == ex_out, (pos == 0) ? "R6 release cycle out" : "R3 strobe", pin_out, ex_out);
      chk(pin_oe == ex_oe, (pos == 0) ? "R6 release cycle oe" : "R4 sink map", pin_oe, ex_oe);
      if (noisy) begin
        frame_in  = $urandom;
        sweeps_in = CW'($urandom % 4);
        start     = (k < n) ? 1'($urandom % 2) : 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R7 R8 end of run", {busy, done}, 2'b01);
    chk(pin_oe == 5'd0 && pin_out == 5'd0, "R8 released at done", {pin_oe, pin_out}, 0);
    chk(last_frame == f[16], "R9 last_frame", last_frame, f[16]);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done single pulse", {busy, done}, 2'b00);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pin_oe == 0 && pin_out == 0 && busy == 0 && done == 0 && last_frame == 0,
        "R1 reset state", {pin_oe, pin_out, busy, done, last_frame}, 0);
    // idle: no start, pads stay released
    repeat (4) @(negedge clk);
    chk(pin_oe == 0 && busy == 0, "R2 idle without start", {pin_oe, busy}, 0);
    run(24'hFFFFFF, 1, 1'b0);               // R4 all LEDs
    run(24'h000000, 2, 1'b0);               // R5 strobes only
    run(24'h1F0000, 1, 1'b0);               // R10 unused bits, R9 end flag
    run(24'h00FFFF, 3, 1'b1);               // R2 input noise while busy
    for (int i = 0; i < 5; i++) run(24'($urandom), 1 + i % 3, 1'b1);
    for (int b = 0; b < 24; b++) run(24'(1) << b, 1, 1'b0);  // R4 single-bit walk
    run(24'($urandom), 0, 1'b0);            // R7 zero means 2^CNT_W
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule